// File: doc/BRIEF.md
# Synchronizer Reference Mode Controller

This block decides which operating mode a network-element clock synchronizer runs in. It takes a two-bit mode command, a flag that says whether the current timing reference is usable, the reference-select value, a lock indication from the loop, and two controls for leaving automatic holdover. From these it produces the current state and a one-hot command for the phase-locked loop: follow the reference, hold the last frequency, or run free. It also raises a flag while a reference swap is in progress.

The loop, its frequency measurement and the oscillator trimming live elsewhere. Lock and reference quality arrive here as plain inputs. There are two holdover states. Automatic holdover is entered when the reference fails, and it can return by itself or only through an explicit operator pulse. Commanded holdover is entered by the mode command or by a change of reference. A change of reference made while the command stays at Normal passes through commanded holdover and comes back once the loop has locked to the new reference.

Reference-valid, reference-select and the return pulse are registered once. Their edges are found by comparing the registered value with the value one cycle older, so each event is seen exactly once. An edge on these inputs therefore acts on the second rising clock edge after it is applied. The mode command, the disable bit and lock act on the first.

Top module: `sync_mode_ctrl`

## Requirements
- R1: While `rst_i` is high the state is RESET (code 0) and the loop command is free-run. On the first clock edge after release the state becomes FREE-RUN (code 4), whatever the mode command is.
- R2: Mode command 2'b10 moves the controller to FREE-RUN from any state on the next clock edge. Only reset ranks above it.
- R3: Mode command 2'b11 is reserved. While it is applied, the state and the pending-switch flag keep their values, except for the exit from RESET.
- R4: From FREE-RUN, mode command 2'b00 leads to NORMAL (code 1) and 2'b01 leads to HOLDOVER (code 3).
- R5: In NORMAL under command 2'b00, a good-to-failed change of `ref_ok_i` moves the controller to AUTO HOLDOVER (code 2).
- R6: In AUTO HOLDOVER with `ret_dis_i` low and command 2'b00, a failed-to-good change of `ref_ok_i` returns the controller to NORMAL.
- R7: In AUTO HOLDOVER with `ret_dis_i` high, a good reference alone does not return the controller. The return happens on the falling edge of a full rise-then-fall of `ret_pulse_i`, and only if the reference is good at that fall and the command is 2'b00. A pulse that ends while the reference is bad is used up and has no effect.
- R8: Command 2'b01 moves NORMAL or AUTO HOLDOVER to HOLDOVER. The controller stays there under 2'b01, and a reference-select change made there has no effect. When the command returns to 2'b00, HOLDOVER goes to NORMAL on the next edge.
- R9: In NORMAL, a change of `ref_sel_i` moves the controller to HOLDOVER and raises `switching_o`. With the command held at 2'b00, the controller returns to NORMAL on the first edge at which `lock_i` is high and the reference is good, and `switching_o` falls at that edge.
- R10: A reference-select change is acted on once. Holding the new value starts no further switch.
- R11: `loop_ctrl_o` is one-hot. Bit 0 means follow the reference (NORMAL). Bit 1 means hold frequency (AUTO HOLDOVER or HOLDOVER). Bit 2 means free-run (FREE-RUN or RESET).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| mode_sel_i | input | 2 | Mode command: 00 Normal, 01 Holdover, 10 Free-run, 11 reserved |
| ref_ok_i | input | 1 | Reference usable (1) or failed (0) |
| ref_sel_i | input | REF_SEL_W | Selected reference index |
| ret_dis_i | input | 1 | Blocks automatic return from automatic holdover |
| ret_pulse_i | input | 1 | Operator return pulse used when return is blocked |
| lock_i | input | 1 | Loop locked to the current reference |
| state_o | output | 3 | Current state code |
| loop_ctrl_o | output | 3 | One-hot loop command (track / hold / free) |
| switching_o | output | 1 | Semi-automatic reference switch in progress |

## Verification
The controller is driven through every state with single-input steps. Each step tells one cause of a transition apart from the others. A reference failure under a disabled return is followed first by a good reference alone, then by a pulse that ends while the reference is still bad, and only then by a proper pulse. This separates a return on the level from a return on the edge, and an armed pulse from a spent one. A reference swap is applied with lock low and then with lock high. This shows both that the flag is held and that the return waits for lock. Holding the new select afterwards shows that the switch is not started twice. The reserved command is applied in HOLDOVER and in FREE-RUN, and the forced free-run command is applied from NORMAL and from HOLDOVER. Together these confirm the priority order of the mode command.

// File: rtl/sync_mode_pkg.sv
package sync_mode_pkg;

   typedef enum logic [2:0] {
      ST_RESET     = 3'd0,
      ST_NORMAL    = 3'd1,
      ST_AUTO_HOLD = 3'd2,
      ST_HOLD      = 3'd3,
      ST_FREE      = 3'd4
   } smc_state_e;

   localparam logic [1:0] MS_NORMAL = 2'b00;
   localparam logic [1:0] MS_HOLD   = 2'b01;
   localparam logic [1:0] MS_FREE   = 2'b10;
   localparam logic [1:0] MS_RSVD   = 2'b11;

   localparam int CTRL_W = 3;
   localparam logic [CTRL_W-1:0] CTRL_TRACK = 3'b001;
   localparam logic [CTRL_W-1:0] CTRL_HOLD  = 3'b010;
   localparam logic [CTRL_W-1:0] CTRL_FREE  = 3'b100;

endpackage

// File: rtl/smc_edge_cap.sv
module smc_edge_cap #(
   parameter int REF_SEL_W    = 2,
   parameter int EXTRA_STAGES = 0
) (
   input  logic                 clk_i,
   input  logic                 rst_i,
   input  logic                 ref_ok_i,
   input  logic [REF_SEL_W-1:0] ref_sel_i,
   input  logic                 ret_pulse_i,
   output logic                 ok_q_o,
   output logic                 ok_rose_o,
   output logic                 ok_fell_o,
   output logic                 sel_chg_o,
   output logic                 pulse_rose_o,
   output logic                 pulse_fell_o
);
   localparam int PW = REF_SEL_W + 2;

   initial begin
      if (REF_SEL_W < 1) $error("REF_SEL_W must be at least 1");
      if (EXTRA_STAGES < 0 || EXTRA_STAGES > 4) $error("EXTRA_STAGES out of range 0..4");
   end

   logic [PW-1:0] raw;
   logic [PW-1:0] cur_q, prev_q;
   logic          cur_v, prev_v;

   generate
      if (EXTRA_STAGES == 0) begin : g_direct
         assign raw = {ret_pulse_i, ref_ok_i, ref_sel_i};
      end else begin : g_pipe
         logic [PW-1:0] pipe [EXTRA_STAGES];
         always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i) begin
               for (int i = 0; i < EXTRA_STAGES; i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= {ret_pulse_i, ref_ok_i, ref_sel_i};
               for (int i = 1; i < EXTRA_STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign raw = pipe[EXTRA_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         cur_q  <= '0;
         prev_q <= '0;
         cur_v  <= 1'b0;
         prev_v <= 1'b0;
      end else begin
         cur_q  <= raw;
         prev_q <= cur_q;
         cur_v  <= 1'b1;
         prev_v <= cur_v;
      end
   end

   assign ok_q_o       = cur_q[REF_SEL_W];
   assign ok_rose_o    = prev_v &  cur_q[REF_SEL_W]   & ~prev_q[REF_SEL_W];
   assign ok_fell_o    = prev_v & ~cur_q[REF_SEL_W]   &  prev_q[REF_SEL_W];
   assign pulse_rose_o = prev_v &  cur_q[REF_SEL_W+1] & ~prev_q[REF_SEL_W+1];
   assign pulse_fell_o = prev_v & ~cur_q[REF_SEL_W+1] &  prev_q[REF_SEL_W+1];
   assign sel_chg_o    = prev_v & (cur_q[REF_SEL_W-1:0] != prev_q[REF_SEL_W-1:0]);

endmodule

// File: rtl/smc_next_state.sv
module smc_next_state
   import sync_mode_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic [1:0] mode_sel_i,
   input  logic       ret_dis_i,
   input  logic       lock_i,
   input  logic       ok_q_i,
   input  logic       ok_rose_i,
   input  logic       ok_fell_i,
   input  logic       sel_chg_i,
   input  logic       pulse_rose_i,
   input  logic       pulse_fell_i,
   output smc_state_e state_o,
   output logic       pending_o
);
   smc_state_e state_q, state_d;
   logic       pend_q, pend_d;
   logic       arm_q, arm_d;

   always_comb begin
      state_d = state_q;
      pend_d  = pend_q;
      arm_d   = arm_q;
      if (state_q == ST_RESET) begin
         state_d = ST_FREE;
      end else if (mode_sel_i == MS_FREE) begin
         state_d = ST_FREE;
      end else if (mode_sel_i != MS_RSVD) begin
         unique case (state_q)
            ST_FREE: begin
               state_d = (mode_sel_i == MS_NORMAL) ? ST_NORMAL : ST_HOLD;
            end
            ST_NORMAL: begin
               if (mode_sel_i == MS_HOLD) begin
                  state_d = ST_HOLD;
               end else if (sel_chg_i) begin
                  state_d = ST_HOLD;
                  pend_d  = 1'b1;
               end else if (ok_fell_i) begin
                  state_d = ST_AUTO_HOLD;
               end
            end
            ST_AUTO_HOLD: begin
               if (mode_sel_i == MS_HOLD) begin
                  state_d = ST_HOLD;
               end else if (!ret_dis_i) begin
                  if (ok_rose_i) state_d = ST_NORMAL;
               end else begin
                  if (pulse_rose_i) arm_d = 1'b1;
                  if (pulse_fell_i) begin
                     arm_d = 1'b0;
                     if (arm_q && ok_q_i) state_d = ST_NORMAL;
                  end
               end
            end
            ST_HOLD: begin
               if (mode_sel_i == MS_NORMAL) begin
                  if (!pend_q || (lock_i && ok_q_i)) state_d = ST_NORMAL;
               end
            end
            default: state_d = ST_FREE;
         endcase
      end
      if (state_d != ST_HOLD)      pend_d = 1'b0;
      if (state_d != ST_AUTO_HOLD) arm_d  = 1'b0;
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         state_q <= ST_RESET;
         pend_q  <= 1'b0;
         arm_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         pend_q  <= pend_d;
         arm_q   <= arm_d;
      end
   end

   assign state_o   = state_q;
   assign pending_o = pend_q;

   // R1: reset exit always lands in free-run
   assert_reset_exit_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_RESET) |=> (state_q == ST_FREE));

   // R2: forced free-run command
   assert_force_free_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_sel_i == MS_FREE) |=> (state_q == ST_FREE));

   // R3: reserved command freezes the state outside RESET
   assert_rsvd_hold_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_sel_i == MS_RSVD && state_q != ST_RESET) |=> (state_q == $past(state_q)));

   // R8: commanded holdover from NORMAL
   assert_cmd_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_NORMAL && mode_sel_i == MS_HOLD) |=> (state_q == ST_HOLD));

   // R5: reference failure in NORMAL
   assert_ref_fail_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_NORMAL && mode_sel_i == MS_NORMAL && ok_fell_i && !sel_chg_i)
      |=> (state_q == ST_AUTO_HOLD));

endmodule

// File: rtl/smc_ctrl_decode.sv
module smc_ctrl_decode
   import sync_mode_pkg::*;
(
   input  smc_state_e        state_i,
   output logic [CTRL_W-1:0] loop_ctrl_o
);
   always_comb begin
      unique case (state_i)
         ST_NORMAL:             loop_ctrl_o = CTRL_TRACK;
         ST_AUTO_HOLD, ST_HOLD: loop_ctrl_o = CTRL_HOLD;
         default:               loop_ctrl_o = CTRL_FREE;
      endcase
   end
endmodule

// File: rtl/sync_mode_ctrl.sv
module sync_mode_ctrl
   import sync_mode_pkg::*;
#(
   parameter int REF_SEL_W    = 2,
   parameter int EXTRA_STAGES = 0
) (
   input  logic                 clk_i,
   input  logic                 rst_i,
   input  logic [1:0]           mode_sel_i,
   input  logic                 ref_ok_i,
   input  logic [REF_SEL_W-1:0] ref_sel_i,
   input  logic                 ret_dis_i,
   input  logic                 ret_pulse_i,
   input  logic                 lock_i,
   output logic [2:0]           state_o,
   output logic [2:0]           loop_ctrl_o,
   output logic                 switching_o
);
   logic       ok_q, ok_rose, ok_fell, sel_chg, p_rose, p_fell;
   smc_state_e cur_state;

   smc_edge_cap #(
      .REF_SEL_W   (REF_SEL_W),
      .EXTRA_STAGES(EXTRA_STAGES)
   ) u_edge (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .ref_ok_i    (ref_ok_i),
      .ref_sel_i   (ref_sel_i),
      .ret_pulse_i (ret_pulse_i),
      .ok_q_o      (ok_q),
      .ok_rose_o   (ok_rose),
      .ok_fell_o   (ok_fell),
      .sel_chg_o   (sel_chg),
      .pulse_rose_o(p_rose),
      .pulse_fell_o(p_fell)
   );

   smc_next_state u_fsm (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .mode_sel_i  (mode_sel_i),
      .ret_dis_i   (ret_dis_i),
      .lock_i      (lock_i),
      .ok_q_i      (ok_q),
      .ok_rose_i   (ok_rose),
      .ok_fell_i   (ok_fell),
      .sel_chg_i   (sel_chg),
      .pulse_rose_i(p_rose),
      .pulse_fell_i(p_fell),
      .state_o     (cur_state),
      .pending_o   (switching_o)
   );

   smc_ctrl_decode u_dec (
      .state_i    (cur_state),
      .loop_ctrl_o(loop_ctrl_o)
   );

   assign state_o = cur_state;

   // R11: loop command always carries exactly one bit
   assert_ctrl_onehot_R11: assert property (@(posedge clk_i) disable iff (rst_i)
      $countones(loop_ctrl_o) == 1);

   // R9: switch flag only ever seen in commanded holdover
   assert_switch_in_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      switching_o |-> (state_o == 3'd3 && loop_ctrl_o[1]));

endmodule

// File: tb/sync_mode_ctrl_tb.sv
module sync_mode_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int SW = 2;

   typedef struct packed {
      logic [1:0]    ms;
      logic          ok;
      logic [SW-1:0] sel;
      logic          dis;
      logic          pul;
      logic          lock;
      logic [2:0]    st;
      logic [2:0]    ctl;
      logic          sw;
      logic [3:0]    req;
   } vec_t;

   localparam int NV = 29;
   // fields: ms ok sel dis pul lock | state ctrl switching | requirement
   localparam vec_t VECS [NV] = '{
      '{2'd0,1'b1,2'd0,1'b0,1'b0,1'b1, 3'd1,3'b001,1'b0, 4'd4},  // R4 free -> normal
      '{2'd0,1'b0,2'd0,1'b0,1'b0,1'b1, 3'd2,3'b010,1'b0, 4'd5},  // R5 ref fails
      '{2'd0,1'b1,2'd0,1'b0,1'b0,1'b1, 3'd1,3'b001,1'b0, 4'd6},  // R6 auto return
      '{2'd0,1'b0,2'd0,1'b1,1'b0,1'b1, 3'd2,3'b010,1'b0, 4'd5},  // R5 with return blocked
      '{2'd0,1'b1,2'd0,1'b1,1'b0,1'b1, 3'd2,3'b010,1'b0, 4'd7},  // R7 good ref alone
      '{2'd0,1'b1,2'd0,1'b1,1'b1,1'b1, 3'd2,3'b010,1'b0, 4'd7},  // R7 pulse rise only
      '{2'd0,1'b1,2'd0,1'b1,1'b0,1'b1, 3'd1,3'b001,1'b0, 4'd7},  // R7 pulse fall returns
      '{2'd0,1'b0,2'd0,1'b1,1'b0,1'b1, 3'd2,3'b010,1'b0, 4'd5},  // R5
      '{2'd0,1'b0,2'd0,1'b1,1'b1,1'b1, 3'd2,3'b010,1'b0, 4'd7},  // R7 pulse with bad ref
      '{2'd0,1'b0,2'd0,1'b1,1'b0,1'b1, 3'd2,3'b010,1'b0, 4'd7},  // R7 fall while bad
      '{2'd0,1'b1,2'd0,1'b1,1'b0,1'b1, 3'd2,3'b010,1'b0, 4'd7},  // R7 spent pulse
      '{2'd0,1'b1,2'd0,1'b1,1'b1,1'b1, 3'd2,3'b010,1'b0, 4'd7},  // R7 new rise
      '{2'd0,1'b1,2'd0,1'b1,1'b0,1'b1, 3'd1,3'b001,1'b0, 4'd7},  // R7 new fall returns
      '{2'd0,1'b1,2'd1,1'b1,1'b0,1'b0, 3'd3,3'b010,1'b1, 4'd9},  // R9 select change
      '{2'd0,1'b1,2'd1,1'b1,1'b0,1'b0, 3'd3,3'b010,1'b1, 4'd10}, // R10 waits for lock
      '{2'd0,1'b1,2'd1,1'b1,1'b0,1'b1, 3'd1,3'b001,1'b0, 4'd9},  // R9 lock returns
      '{2'd0,1'b1,2'd1,1'b1,1'b0,1'b1, 3'd1,3'b001,1'b0, 4'd10}, // R10 no second switch
      '{2'd1,1'b1,2'd1,1'b1,1'b0,1'b1, 3'd3,3'b010,1'b0, 4'd8},  // R8 commanded hold
      '{2'd1,1'b1,2'd2,1'b1,1'b0,1'b1, 3'd3,3'b010,1'b0, 4'd8},  // R8 manual swap
      '{2'd0,1'b1,2'd2,1'b1,1'b0,1'b1, 3'd1,3'b001,1'b0, 4'd8},  // R8 back to normal
      '{2'd2,1'b1,2'd2,1'b1,1'b0,1'b1, 3'd4,3'b100,1'b0, 4'd2},  // R2 from normal
      '{2'd1,1'b1,2'd2,1'b1,1'b0,1'b1, 3'd3,3'b010,1'b0, 4'd4},  // R4 free -> hold
      '{2'd3,1'b1,2'd2,1'b1,1'b0,1'b1, 3'd3,3'b010,1'b0, 4'd3},  // R3 reserved in hold
      '{2'd0,1'b1,2'd2,1'b1,1'b0,1'b1, 3'd1,3'b001,1'b0, 4'd8},  // R8
      '{2'd0,1'b0,2'd2,1'b1,1'b0,1'b1, 3'd2,3'b010,1'b0, 4'd5},  // R5
      '{2'd1,1'b0,2'd2,1'b1,1'b0,1'b1, 3'd3,3'b010,1'b0, 4'd8},  // R8 auto -> commanded
      '{2'd2,1'b0,2'd2,1'b1,1'b0,1'b1, 3'd4,3'b100,1'b0, 4'd2},  // R2 from hold
      '{2'd3,1'b1,2'd2,1'b1,1'b0,1'b1, 3'd4,3'b100,1'b0, 4'd3},  // R3 reserved in free
      '{2'd0,1'b1,2'd2,1'b0,1'b0,1'b1, 3'd1,3'b001,1'b0, 4'd4}   // R4
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    ms = 2'd3;
   logic          ok = 1'b1;
   logic [SW-1:0] sel = '0;
   logic          dis = 1'b0;
   logic          pul = 1'b0;
   logic          lock = 1'b1;
   logic [2:0]    st, ctl;
   logic          sw;
   int            n_cmp = 0;
   int            n_bad = 0;
   bit            done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sync_mode_ctrl #(.REF_SEL_W(SW)) u_dut (
      .clk_i(clk), .rst_i(rst), .mode_sel_i(ms), .ref_ok_i(ok), .ref_sel_i(sel),
      .ret_dis_i(dis), .ret_pulse_i(pul), .lock_i(lock),
      .state_o(st), .loop_ctrl_o(ctl), .switching_o(sw)
   );

   task automatic expect_out(input logic [2:0] es, input logic [2:0] ec, input logic esw,
                             input int req);
      n_cmp++;
      if (st !== es || ctl !== ec || sw !== esw) begin
         n_bad++;
         $display("FAIL R%0d: state=%0d ctrl=%b sw=%b expected state=%0d ctrl=%b sw=%b",
                  req, st, ctl, sw, es, ec, esw);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      expect_out(3'd0, 3'b100, 1'b0, 1);           // R1 held in reset
      rst = 1'b0;                                  // reserved command during release
      @(posedge clk); @(negedge clk);
      expect_out(3'd4, 3'b100, 1'b0, 1);           // R1 exit to free-run
      repeat (2) @(negedge clk);
      expect_out(3'd4, 3'b100, 1'b0, 3);           // R3 reserved keeps free-run

      for (int i = 0; i < NV; i++) begin
         ms = VECS[i].ms; ok = VECS[i].ok; sel = VECS[i].sel;
         dis = VECS[i].dis; pul = VECS[i].pul; lock = VECS[i].lock;
         repeat (2) @(posedge clk);
         @(negedge clk);
         expect_out(VECS[i].st, VECS[i].ctl, VECS[i].sw, int'(VECS[i].req));
      end

      // R1: reset in the middle of operation
      rst = 1'b1;
      #1;
      expect_out(3'd0, 3'b100, 1'b0, 1);
      @(negedge clk);
      ms = 2'd0;
      rst = 1'b0;
      @(posedge clk); @(negedge clk);
      expect_out(3'd4, 3'b100, 1'b0, 1);           // R1 first edge -> free-run
      @(posedge clk); @(negedge clk);
      expect_out(3'd1, 3'b001, 1'b0, 4);           // R4 then normal
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (5000) @(posedge clk);
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
         end
      join_any
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule